// File: doc/BRIEF.md
# Width-Converting Dual-Clock FIFO with Double-Rate Read Port

This block moves 40-bit words from one clock domain to another. The producer writes one full word on each rising edge of its clock. The consumer reads each stored word as two 20-bit halves, one on each edge of its own clock. The block therefore halves the bus width and doubles the transfer rate at the same time. The two clocks have no fixed relationship.

Storage is a power-of-two array of 40-bit entries. Each side keeps a binary pointer and a Gray-coded copy of that pointer. Each Gray pointer crosses to the other side through a two-flop synchroniser. The active-low full flag is computed only from write-clock state. The active-low empty flag is computed only from read-clock state. The read data bus drives only while both the read chip select and the output enable are low; otherwise it is released to high impedance.

A read is accepted on a rising read-clock edge. The lower half of the word is shown for the high phase that follows that edge, and the upper half for the low phase after it. The storage slot is released only on the falling edge that delivers the upper half. The single reset input is active high and synchronous; it must be held across several edges of both clocks.

Top module: `ddr_bus_fifo`

## Requirements
- R1: A word on `din` is stored at a rising `wr_clk` edge when `wr_en` is 1, `wr_cs_n` is 0 and `full_n` is 1. Words are read back in the order they were written.
- R2: A read is accepted at a rising `rd_clk` edge when `rd_en` is 1, `rd_cs_n` is 0 and `empty_n` is 1. During the high phase after that edge `q` carries bits 19:0 of the oldest word. During the following low phase `q` carries bits 39:20.
- R3: While `full_n` is 0, write attempts are ignored: nothing is stored and no stored word is overwritten.
- R4: With no reads, `full_n` is 1 after DEPTH-1 accepted writes and goes to 0 after the DEPTH-th. The count of stored words never exceeds DEPTH.
- R5: When a full FIFO releases a word, `full_n` returns to 1 after two rising `wr_clk` edges following the releasing `rd_clk` falling edge, or after three edges when the two clock edges fall too close together.
- R6: A word's slot is released on the `rd_clk` falling edge that presents its upper half, not on the rising edge that accepted the read. With one word stored, `empty_n` stays 1 through the high phase and becomes 0 at that falling edge.
- R7: With `rd_cs_n` at 1, `q` is high impedance and read attempts are ignored; the word stays queued. With `oe_n` at 1, `q` is also high impedance.
- R8: `empty_n` is 0 when no word is stored. A read attempt while empty changes nothing, and `q` keeps showing the halves of the last word read.
- R9: While `rst` is 1, both pointers are cleared, `full_n` is 1, `empty_n` is 0 and both output halves are zero.
- R10: Each Gray pointer changes in at most one bit per update, so it can cross clock domains safely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock; both edges are used |
| rst | input | 1 | Synchronous reset, active high, held across edges of both clocks |
| wr_en | input | 1 | Write request |
| wr_cs_n | input | 1 | Write chip select, active low |
| din | input | 40 | Write data word |
| full_n | output | 1 | Full flag, active low, write-clock domain |
| rd_en | input | 1 | Read request |
| rd_cs_n | input | 1 | Read chip select, active low; high releases `q` |
| oe_n | input | 1 | Output enable, active low |
| empty_n | output | 1 | Empty flag, active low, read-clock domain |
| q | output | 20 | Read data half-word, tri-state |

## Verification
The bench streams a vector table through the FIFO and compares each half against a scoreboard. A design that swapped the halves or shifted them by an edge would show the wrong half in a phase. It fills the FIFO across a pointer wrap and then keeps writing while full. A design that overwrites its oldest entry in that state would return a marker word in place of the expected data.

It times how many write-clock edges `full_n` takes to recover after a single read. A missing synchroniser stage would shorten this count, and a stuck flag would exceed it. It checks that `empty_n` stays 1 during the lower-half phase of the last word; a design that frees the slot on the rising edge would clear it early. It also attempts reads with chip select high and while empty. A design that consumed a word in either case would lose data or change `q`.

// File: rtl/ddrfifo_pkg.sv
package ddrfifo_pkg;

    localparam int WORD_W = 40;
    localparam int HALF_W = WORD_W / 2;

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
    } word_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/ddrfifo_mem.sv
module ddrfifo_mem
    import ddrfifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  word_t             wdata,
    input  logic [ADDR_W-1:0] raddr,
    output word_t             rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    word_t mem [DEPTH];

    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/ddrfifo_sync.sv
module ddrfifo_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stage[0] <= '0;
                    else     stage[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stage[s] <= '0;
                    else     stage[s] <= stage[s-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];

endmodule

// File: rtl/ddrfifo_wr_ctl.sv
module ddrfifo_wr_ctl
    import ddrfifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_cs_n,
    input  logic [ADDR_W:0]   rd_gray_s,
    output logic              wr_fire,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [ADDR_W:0]   wr_gray,
    output logic              full_n
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] wr_bin;
    logic [PTR_W-1:0] wr_bin_nx;
    logic [PTR_W-1:0] full_pat;

    // Full when the write pointer has lapped the read pointer exactly once.
    assign full_pat = {~rd_gray_s[PTR_W-1:PTR_W-2], rd_gray_s[PTR_W-3:0]};
    assign full_n   = (wr_gray != full_pat);
    assign wr_fire  = wr_en & ~wr_cs_n & full_n;
    assign wr_bin_nx = wr_bin + PTR_W'(1);
    assign wr_addr  = wr_bin[ADDR_W-1:0];

    always_ff @(posedge wr_clk) begin
        if (rst) begin
            wr_bin  <= '0;
            wr_gray <= '0;
        end else if (wr_fire) begin
            wr_bin  <= wr_bin_nx;
            wr_gray <= PTR_W'(bin2gray(32'(wr_bin_nx)));
        end
    end

endmodule

// File: rtl/ddrfifo_rd_ctl.sv
module ddrfifo_rd_ctl
    import ddrfifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              rd_cs_n,
    input  logic [ADDR_W:0]   wr_gray_s,
    input  word_t             rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [ADDR_W:0]   rd_gray,
    output logic              empty_n,
    output logic              rd_fire,
    output logic [HALF_W-1:0] lo_q,
    output logic [HALF_W-1:0] hi_q
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  rd_bin;
    logic [PTR_W-1:0]  rd_bin_nx;
    logic [HALF_W-1:0] hi_stash;
    logic              tog_rise;
    logic              tog_fall;

    assign empty_n   = (rd_gray != wr_gray_s);
    assign rd_fire   = rd_en & ~rd_cs_n & empty_n;
    assign rd_bin_nx = rd_bin + PTR_W'(1);
    assign rd_addr   = rd_bin[ADDR_W-1:0];

    // Rising edge: accept the read, present the lower half, park the upper half.
    always_ff @(posedge rd_clk) begin
        if (rst) begin
            lo_q     <= '0;
            hi_stash <= '0;
            tog_rise <= 1'b0;
        end else if (rd_fire) begin
            lo_q     <= rd_word.lo;
            hi_stash <= rd_word.hi;
            tog_rise <= ~tog_rise;
        end
    end

    // Falling edge: present the upper half, then release the slot.
    always_ff @(negedge rd_clk) begin
        if (rst) begin
            hi_q     <= '0;
            tog_fall <= 1'b0;
            rd_bin   <= '0;
            rd_gray  <= '0;
        end else if (tog_fall != tog_rise) begin
            hi_q     <= hi_stash;
            tog_fall <= tog_rise;
            rd_bin   <= rd_bin_nx;
            rd_gray  <= PTR_W'(bin2gray(32'(rd_bin_nx)));
        end
    end

endmodule

// File: rtl/ddr_bus_fifo.sv
module ddr_bus_fifo
    import ddrfifo_pkg::*;
#(
    parameter int ADDR_W     = 4,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_cs_n,
    input  logic [WORD_W-1:0] din,
    output logic              full_n,
    input  logic              rd_en,
    input  logic              rd_cs_n,
    input  logic              oe_n,
    output logic              empty_n,
    output logic [HALF_W-1:0] q
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  wr_gray, rd_gray, rd_gray_w, wr_gray_r;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic              wr_fire, rd_fire;
    word_t             rd_word;
    logic [HALF_W-1:0] lo_q, hi_q, dq;

    ddrfifo_mem #(.ADDR_W(ADDR_W)) u_mem (
        .wr_clk (wr_clk),
        .we     (wr_fire),
        .waddr  (wr_addr),
        .wdata  (word_t'(din)),
        .raddr  (rd_addr),
        .rdata  (rd_word)
    );

    ddrfifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .wr_clk    (wr_clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_cs_n   (wr_cs_n),
        .rd_gray_s (rd_gray_w),
        .wr_fire   (wr_fire),
        .wr_addr   (wr_addr),
        .wr_gray   (wr_gray),
        .full_n    (full_n)
    );

    ddrfifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
        .rd_clk    (rd_clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .rd_cs_n   (rd_cs_n),
        .wr_gray_s (wr_gray_r),
        .rd_word   (rd_word),
        .rd_addr   (rd_addr),
        .rd_gray   (rd_gray),
        .empty_n   (empty_n),
        .rd_fire   (rd_fire),
        .lo_q      (lo_q),
        .hi_q      (hi_q)
    );

    ddrfifo_sync #(.W(PTR_W), .STAGES(SYNC_DEPTH)) u_sync_r2w (
        .clk (wr_clk),
        .rst (rst),
        .d   (rd_gray),
        .q   (rd_gray_w)
    );

    ddrfifo_sync #(.W(PTR_W), .STAGES(SYNC_DEPTH)) u_sync_w2r (
        .clk (rd_clk),
        .rst (rst),
        .d   (wr_gray),
        .q   (wr_gray_r)
    );

    // Double-rate output: lower half in the high phase, upper half in the low phase.
    assign dq = rd_clk ? lo_q : hi_q;
    assign q  = (!rd_cs_n && !oe_n) ? dq : 'z;

endmodule

// File: rtl/ddrfifo_chk.sv
module ddrfifo_chk
    import ddrfifo_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input logic            wr_clk,
    input logic            rd_clk,
    input logic            rst,
    input logic            wr_en,
    input logic            wr_cs_n,
    input logic            full_n,
    input logic            empty_n,
    input logic [ADDR_W:0] wr_gray,
    input logic [ADDR_W:0] rd_gray,
    input logic [ADDR_W:0] rd_gray_w,
    input logic [ADDR_W:0] wr_gray_r
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PTR_W-1:0] wdist, rdist;
    assign wdist = PTR_W'(gray2bin(32'(wr_gray)) - gray2bin(32'(rd_gray_w)));
    assign rdist = PTR_W'(gray2bin(32'(wr_gray_r)) - gray2bin(32'(rd_gray)));

    assert_gray_step_wr_R10: assert property (@(posedge wr_clk) disable iff (rst)
        $onehot0(wr_gray ^ $past(wr_gray)));

    assert_gray_step_rd_R10: assert property (@(negedge rd_clk) disable iff (rst)
        $onehot0(rd_gray ^ $past(rd_gray)));

    assert_drop_when_full_R3: assert property (@(posedge wr_clk) disable iff (rst)
        (!full_n && wr_en && !wr_cs_n) |=> $stable(wr_gray));

    assert_full_at_depth_R4: assert property (@(posedge wr_clk) disable iff (rst)
        !full_n |-> (wdist == PTR_W'(DEPTH)));

    assert_no_overflow_R4: assert property (@(posedge wr_clk) disable iff (rst)
        wdist <= PTR_W'(DEPTH));

    assert_no_underflow_R8: assert property (@(posedge rd_clk) disable iff (rst)
        rdist <= PTR_W'(DEPTH));

    assert_empty_means_zero_R8: assert property (@(posedge rd_clk) disable iff (rst)
        !empty_n |-> (rdist == '0));

    assert_reset_flags_R9: assert property (@(posedge wr_clk)
        $past(rst) |-> full_n);

endmodule

bind ddr_bus_fifo ddrfifo_chk #(.ADDR_W(ADDR_W)) u_chk (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_cs_n   (wr_cs_n),
    .full_n    (full_n),
    .empty_n   (empty_n),
    .wr_gray   (wr_gray),
    .rd_gray   (rd_gray),
    .rd_gray_w (rd_gray_w),
    .wr_gray_r (wr_gray_r)
);

// File: tb/sim_ddr_bus_fifo.sv
module sim_ddr_bus_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int RD_HALF    = 7;
    localparam int ADDR_W     = 4;
    localparam int DEPTH      = 1 << ADDR_W;

    localparam logic [39:0] VEC [8] = '{
        40'h12345_6789A, 40'hFFFFF_00000, 40'h00000_FFFFF, 40'hA5A5A_5A5A5,
        40'h00001_80000, 40'hDEADB_EEF01, 40'h13579_2468A, 40'hC0FFE_E0042
    };

    logic wr_clk = 0, rd_clk = 0, rst = 1;
    logic wr_en = 0, wr_cs_n = 0, rd_en = 0, rd_cs_n = 0, oe_n = 0;
    logic [39:0] din = '0;
    logic full_n, empty_n;
    wire  [19:0] q;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [39:0] sb [$];

    ddr_bus_fifo #(.ADDR_W(ADDR_W)) u0 (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .rst(rst), .wr_en(wr_en),
        .wr_cs_n(wr_cs_n), .din(din), .full_n(full_n), .rd_en(rd_en),
        .rd_cs_n(rd_cs_n), .oe_n(oe_n), .empty_n(empty_n), .q(q)
    );

    initial forever #(CLK_PERIOD/2) wr_clk = ~wr_clk;
    initial begin #2; forever #(RD_HALF) rd_clk = ~rd_clk; end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [39:0] d, output bit acc);
        @(negedge wr_clk); #1;
        acc = full_n;
        wr_en = 1; din = d;
        @(negedge wr_clk); #1;
        wr_en = 0;
        if (acc) sb.push_back(d);
    endtask

    task automatic pop(output logic [19:0] lo, output logic [19:0] hi, output bit took);
        @(negedge rd_clk); #1;
        took = empty_n && !rd_cs_n;
        rd_en = 1;
        @(posedge rd_clk); #3;
        lo = q;
        rd_en = 0;
        @(negedge rd_clk); #3;
        hi = q;
    endtask

    task automatic pop_check(input string req);
        logic [19:0] lo, hi; bit took; logic [39:0] e;
        pop(lo, hi, took);
        e = sb.pop_front();
        chk({req, " lower half"}, 64'(lo), 64'(e[19:0]));
        chk({req, " upper half"}, 64'(hi), 64'(e[39:20]));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        bit acc; bit took; logic [19:0] lo, hi; int n;

        // R9: reset state
        repeat (4) @(posedge rd_clk);
        @(negedge rd_clk); #3;
        chk("R9 full_n in reset", 64'(full_n), 64'(1));
        chk("R9 empty_n in reset", 64'(empty_n), 64'(0));
        @(negedge wr_clk); rst = 0;
        @(posedge rd_clk); #3;
        chk("R9 q lower after reset", 64'(q), 64'(0));

        // R1, R2: table walk
        for (int i = 0; i < 8; i++) push(VEC[i], acc);
        repeat (4) @(posedge rd_clk);
        chk("R1 data visible", 64'(empty_n), 64'(1));
        for (int i = 0; i < 8; i++) pop_check("R2 table");
        #1;
        chk("R8 empty after drain", 64'(empty_n), 64'(0));

        // R8: read while empty keeps last halves
        pop(lo, hi, took);
        chk("R8 empty read ignored", 64'(took), 64'(0));
        chk("R8 lower held", 64'(lo), 64'(VEC[7][19:0]));
        chk("R8 upper held", 64'(hi), 64'(VEC[7][39:20]));

        // R4: fill across pointer wrap
        for (int i = 0; i < DEPTH - 1; i++) push({8'(i), 32'hC3A5_0000 | 32'(i)}, acc);
        chk("R4 not full at DEPTH-1", 64'(full_n), 64'(1));
        push(40'hF0F0F_0F0F0, acc);
        chk("R4 full at DEPTH", 64'(full_n), 64'(0));

        // R3: writes while full dropped
        for (int i = 0; i < 3; i++) push(40'hBADBA_DBAD0 + 40'(i), acc);
        chk("R3 still full", 64'(full_n), 64'(0));

        // R5: full_n recovery latency after one release
        @(negedge rd_clk); #1; rd_en = 1;
        @(posedge rd_clk); #1; rd_en = 0;
        lo = q;
        chk("R5 released word lower", 64'(lo), 64'(sb[0][19:0]));
        void'(sb.pop_front());
        @(negedge rd_clk);
        n = 0;
        while (n < 8) begin
            @(posedge wr_clk); n++; #1;
            if (full_n) break;
        end
        chk("R5 recovery edges in 2..3", 64'(n >= 2 && n <= 3), 64'(1));

        // R3/R1: drain, markers must be absent
        while (sb.size() > 1) pop_check("R3 order after full");

        // R6: last word frees only at falling edge
        @(negedge rd_clk); #1; rd_en = 1;
        @(posedge rd_clk); #3; rd_en = 0;
        chk("R6 empty_n held in high phase", 64'(empty_n), 64'(1));
        chk("R6 lower of last word", 64'(q), 64'(sb[0][19:0]));
        @(negedge rd_clk); #1;
        chk("R6 empty_n after falling edge", 64'(empty_n), 64'(0));
        void'(sb.pop_front());

        // R7: chip select and output enable
        push(40'h7E7E7_81818, acc);
        repeat (4) @(posedge rd_clk);
        rd_cs_n = 1;
        pop(lo, hi, took);
        chk("R7 cs high no read", 64'(took), 64'(0));
        chk("R7 cs high q released", 64'((lo === 20'bz) || (lo === 20'h0)), 64'(1));
        chk("R7 word still queued", 64'(empty_n), 64'(1));
        rd_cs_n = 0; oe_n = 1;
        @(posedge rd_clk); #3;
        chk("R7 oe high q released", 64'((q === 20'bz) || (q === 20'h0)), 64'(1));
        oe_n = 0;
        pop_check("R7 word after cs high");

        finish_run();
    end
endmodule